// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Crossover Delay

This block turns the two logic command inputs of each full bridge into four gate enables, a source (high-side) enable and a sink (low-side) enable for each of the bridge's two output legs. It decodes four commands: idle with every switch open, forward, reverse, and a brake that closes both sinks. A per-bridge high-side-permit input from the current chopper takes the source drive away during chopper off-time. While the permit is low, the leg that was sourcing closes its sink instead, so the winding current recirculates through switches rather than body diodes (slow decay with synchronous rectification).

Every gate turn-on is held back until both gates of that leg have been open for a programmable number of clock cycles. A source and a sink on the same leg therefore never conduct together, and each source-to-sink or sink-to-source swap carries a crossover gap. A global drive enable, driven low by sleep or fault logic, opens every gate at once without waiting for a clock edge. The number of bridges is a parameter, and the default of two serves a dual bridge.

Top module: `hbridge_gate_seq`

## Requirements
- R1: Each bridge b reads its command as {in_a, in_b} = {cmd[2b+1], cmd[2b]}. Leg A of bridge b owns gate bit 2b and leg B owns bit 2b+1. With the permit high, command 10 closes the source of leg A and the sink of leg B, and command 01 closes the sink of leg A and the source of leg B.
- R2: Command 00 opens both gates of both legs of that bridge at the first clock edge. When every command bit of every bridge is 0, all gate outputs are 0.
- R3: Command 11 (brake) closes both sinks of the bridge and never a source, whatever the level of the permit input.
- R4: While a bridge's permit is low under command 10 or 01, its sourcing leg opens its source and, after the crossover gap, closes its sink. When the permit returns high, the source is restored after the crossover gap.
- R5: No leg ever has its source and sink enables asserted together.
- R6: A gate of a leg turns on only after both gates of that leg have been open for at least DEAD_CYC consecutive cycles. A swap shows both gates open from the first edge after the command and the new gate from edge DEAD_CYC+1.
- R7: A gate whose command drops is opened at the first clock edge. A gate on a leg that has been idle for DEAD_CYC cycles or more turns on at the first clock edge after its command.
- R8: With drive_en low, all gate outputs are 0 in the same cycle, before any clock edge. While drive_en stays low across an edge, the leg state clears. After drive_en returns high, gates come back under the crossover rule.
- R9: During reset all gate outputs are 0. A leg leaves reset counted as idle long enough to turn on at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| drive_en | input | 1 | Global gate enable; low opens every gate immediately |
| cmd | input | 2*NUM_BRIDGES | Per-bridge command {in_a, in_b} |
| hs_ok | input | NUM_BRIDGES | Per-bridge high-side permit from the current chopper |
| gate_hi | output | 2*NUM_BRIDGES | Source (high-side) enable per leg |
| gate_lo | output | 2*NUM_BRIDGES | Sink (low-side) enable per leg |

## Verification
Each result has a fixed latency:
- drive_en low acts in the same cycle.
- A gate turn-off, or a turn-on from a long-idle leg, appears one edge after the command.
- The new gate of a swap appears DEAD_CYC+1 edges after the command, and both gates read open at edge DEAD_CYC.

The driver applies inputs just after a rising edge and queues each expected gate pattern tagged with the cycle in which it is due, counted in edges from that drive. The monitor compares only in that cycle, at the falling edge. The checks cover the last open cycle and the first closed cycle of every gap, so an early or late turn-on is caught.

// File: rtl/hbg_pkg.sv
// Package: types shared by the H-bridge gate sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package hbg_pkg;
    // Requested state of one output leg.
    typedef enum logic [1:0] {
        LEG_OPEN = 2'd0,
        LEG_SRC  = 2'd1,
        LEG_SNK  = 2'd2
    } leg_mode_e;
endpackage

// File: rtl/hbg_cmd_decode.sv
// Module: hbg_cmd_decode
// Turns one bridge's two command bits and the chopper permit into the
// requested mode of each leg. Purely combinational.
// Assumes: cmd = {in_a, in_b}; a low permit replaces a source with its sink.
module hbg_cmd_decode
    import hbg_pkg::*;
(
    input  logic [1:0] cmd,
    input  logic       hs_ok,
    output leg_mode_e  mode_a,
    output leg_mode_e  mode_b
);
    logic [1:0] cmd_sel;
    assign cmd_sel = cmd;

    // Map command and permit onto the two leg requests.
    always_comb begin
        mode_a = LEG_OPEN;
        mode_b = LEG_OPEN;
        case (cmd_sel)
            2'b10: begin
                mode_a = hs_ok ? LEG_SRC : LEG_SNK;
                mode_b = LEG_SNK;
            end
            2'b01: begin
                mode_a = LEG_SNK;
                mode_b = hs_ok ? LEG_SRC : LEG_SNK;
            end
            2'b11: begin
                mode_a = LEG_SNK;
                mode_b = LEG_SNK;
            end
            default: begin
                mode_a = LEG_OPEN;
                mode_b = LEG_OPEN;
            end
        endcase
    end
endmodule

// File: rtl/hbg_leg_timer.sv
// Module: hbg_leg_timer
// Holds the two gate enables of one leg. A gate opens at the first edge
// after its request drops. A gate closes only once both gates have been
// open for DEAD_CYC consecutive cycles, counted by a saturating counter.
// Assumes: DEAD_CYC >= 1; en low clears the leg at the next edge (the
// immediate force-off is applied at the top level).
module hbg_leg_timer
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  leg_mode_e want,
    output logic      hi_q,
    output logic      lo_q
);
    localparam int GW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [GW-1:0] GAP_READY = GW'(DEAD_CYC - 1);

    logic [GW-1:0] gap_q;
    logic          hi_d, lo_d;
    logic          any_on, on_matches, gap_ok;

    assign any_on     = hi_q | lo_q;
    assign on_matches = (hi_q && want == LEG_SRC) || (lo_q && want == LEG_SNK);
    assign gap_ok     = (gap_q == GAP_READY);

    // Next gate state: open on mismatch, close only after the idle gap.
    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (!en) begin
            hi_d = 1'b0;
            lo_d = 1'b0;
        end else if (any_on) begin
            if (!on_matches) begin
                hi_d = 1'b0;
                lo_d = 1'b0;
            end
        end else if (gap_ok) begin
            hi_d = (want == LEG_SRC);
            lo_d = (want == LEG_SNK);
        end
    end

    // Gate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    // Idle-gap counter: cycles with both gates open, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_READY;
        end else if (any_on) begin
            gap_q <= '0;
        end else if (!gap_ok) begin
            gap_q <= gap_q + 1'b1;
        end
    end
endmodule

// File: rtl/hbg_bridge.sv
// Module: hbg_bridge
// One full bridge: the command decoder feeding two leg timers.
// Assumes: gate bit 0 is leg A, bit 1 is leg B.
module hbg_bridge
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] cmd,
    input  logic       hs_ok,
    output logic [1:0] hi_q,
    output logic [1:0] lo_q
);
    leg_mode_e mode_a, mode_b;

    hbg_cmd_decode u_dec (
        .cmd    (cmd),
        .hs_ok  (hs_ok),
        .mode_a (mode_a),
        .mode_b (mode_b)
    );

    hbg_leg_timer #(.DEAD_CYC(DEAD_CYC)) u_leg_a (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .want  (mode_a),
        .hi_q  (hi_q[0]),
        .lo_q  (lo_q[0])
    );

    hbg_leg_timer #(.DEAD_CYC(DEAD_CYC)) u_leg_b (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .want  (mode_b),
        .hi_q  (hi_q[1]),
        .lo_q  (lo_q[1])
    );
endmodule

// File: rtl/hbridge_gate_seq.sv
// Module: hbridge_gate_seq (top)
// NUM_BRIDGES bridges side by side, each with its own command pair and
// permit. drive_en gates every output combinationally, so a sleep or fault
// opens all switches before the next edge.
// Assumes: inputs are synchronous to clk; DEAD_CYC >= 1.
module hbridge_gate_seq #(
    parameter int NUM_BRIDGES = 2,
    parameter int DEAD_CYC    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     drive_en,
    input  logic [2*NUM_BRIDGES-1:0] cmd,
    input  logic [NUM_BRIDGES-1:0]   hs_ok,
    output logic [2*NUM_BRIDGES-1:0] gate_hi,
    output logic [2*NUM_BRIDGES-1:0] gate_lo
);
    localparam int NL = 2 * NUM_BRIDGES;

    logic [NL-1:0] hi_raw, lo_raw;

    // One bridge per command pair.
    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
        hbg_bridge #(.DEAD_CYC(DEAD_CYC)) u_br (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (drive_en),
            .cmd   (cmd[2*b +: 2]),
            .hs_ok (hs_ok[b]),
            .hi_q  (hi_raw[2*b +: 2]),
            .lo_q  (lo_raw[2*b +: 2])
        );
    end

    // Immediate force-off by the global enable.
    assign gate_hi = hi_raw & {NL{drive_en}};
    assign gate_lo = lo_raw & {NL{drive_en}};
endmodule

// File: rtl/hbg_checker.sv
// Module: hbg_checker
// Port-level properties of hbridge_gate_seq, bound to every instance.
// Assumes: same parameters as the bound top.
module hbg_checker #(
    parameter int NUM_BRIDGES = 2,
    parameter int DEAD_CYC    = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     drive_en,
    input logic [2*NUM_BRIDGES-1:0] cmd,
    input logic [NUM_BRIDGES-1:0]   hs_ok,
    input logic [2*NUM_BRIDGES-1:0] gate_hi,
    input logic [2*NUM_BRIDGES-1:0] gate_lo
);
    localparam int NL = 2 * NUM_BRIDGES;
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(DEAD_CYC);

    // R5: source and sink of a leg never on together.
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R8: enable low means every gate open.
    a_r8_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (gate_hi == '0 && gate_lo == '0));

    for (genvar l = 0; l < NL; l++) begin : g_leg
        logic [CW-1:0] idle_cnt;
        logic          was_on;
        // Count sampled cycles with both gates of this leg open.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idle_cnt <= CMAX;
                was_on   <= 1'b0;
            end else begin
                was_on <= gate_hi[l] | gate_lo[l];
                if (gate_hi[l] | gate_lo[l]) idle_cnt <= '0;
                else if (idle_cnt != CMAX)   idle_cnt <= idle_cnt + 1'b1;
            end
        end
        // R6: a turn-on follows at least DEAD_CYC open cycles.
        a_r6_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
            ((gate_hi[l] | gate_lo[l]) && !was_on) |-> (idle_cnt >= CMAX));
    end

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
        // R3: a held brake never drives a source.
        a_r3_brake_no_source: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd[2*b +: 2] == 2'b11 && $past(cmd[2*b +: 2]) == 2'b11)
                |-> gate_hi[2*b +: 2] == 2'b00);
        // R4: a permit held low keeps both sources of the bridge open.
        a_r4_permit_low_no_source: assert property (@(posedge clk) disable iff (!rst_n)
            (!hs_ok[b] && !$past(hs_ok[b])) |-> gate_hi[2*b +: 2] == 2'b00);
    end
endmodule

bind hbridge_gate_seq hbg_checker #(
    .NUM_BRIDGES (NUM_BRIDGES),
    .DEAD_CYC    (DEAD_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_en (drive_en),
    .cmd      (cmd),
    .hs_ok    (hs_ok),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
);

// File: tb/sim_hbridge_gate_seq.sv
module sim_hbridge_gate_seq;
    localparam int NB = 2;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          drive_en = 1'b1;
    logic [3:0]    cmd = 4'b0000;
    logic [1:0]    hs_ok = 2'b11;
    logic [3:0]    gate_hi, gate_lo;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [3:0] hi;
        logic [3:0] lo;
        string      tag;
    } exp_t;
    exp_t sb[$];

    hbridge_gate_seq #(.NUM_BRIDGES(NB), .DEAD_CYC(D)) u0 (
        .clk(clk), .rst_n(rst_n), .drive_en(drive_en),
        .cmd(cmd), .hs_ok(hs_ok), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // Driver: apply inputs just after a rising edge.
    task automatic drive(input logic [3:0] c, input logic [1:0] h, input logic e);
        @(posedge clk);
        #1;
        cmd = c; hs_ok = h; drive_en = e;
    endtask

    // Queue an expectation k edges after the current drive point.
    task automatic expect_at(input int k, input logic [3:0] h, input logic [3:0] l,
                             input string tag);
        exp_t it;
        it.due = cyc + k; it.hi = h; it.lo = l; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Monitor: compare due items at the falling edge.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                checks++;
                if (gate_hi !== sb[i].hi || gate_lo !== sb[i].lo) begin
                    failures++;
                    $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b",
                             sb[i].tag, gate_hi, gate_lo, sb[i].hi, sb[i].lo);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        // R9: reset holds every gate open, even with a command present.
        drive(4'b0010, 2'b11, 1'b1);
        expect_at(1, 4'b0000, 4'b0000, "R9 reset state");
        idle(3);
        drive(4'b0000, 2'b11, 1'b1);
        rst_n = 1'b1;
        idle(3);

        // R1 R7 R9: forward on bridge 0 from idle, one edge.
        drive(4'b0010, 2'b11, 1'b1);
        expect_at(0, 4'b0000, 4'b0000, "R7 before edge");
        expect_at(1, 4'b0001, 4'b0010, "R1 forward bridge0");
        idle(D + 2);

        // R1: reverse on bridge 1.
        drive(4'b0110, 2'b11, 1'b1);
        expect_at(1, 4'b1001, 4'b0110, "R1 reverse bridge1");
        idle(D + 2);

        // R6: swap bridge 0 from forward to reverse.
        drive(4'b0101, 2'b11, 1'b1);
        expect_at(1, 4'b1000, 4'b0100, "R6 swap first edge open");
        expect_at(D, 4'b1000, 4'b0100, "R6 swap last open cycle");
        expect_at(D + 1, 4'b1010, 4'b0101, "R6 swap new gates");
        idle(D + 3);

        // R4: permit low on bridge 0, sourcing leg B moves to its sink.
        drive(4'b0101, 2'b10, 1'b1);
        expect_at(1, 4'b1000, 4'b0101, "R4 source opened");
        expect_at(D, 4'b1000, 4'b0101, "R4 gap held");
        expect_at(D + 1, 4'b1000, 4'b0111, "R4 sync-rect sink");
        idle(D + 3);

        // R4: permit restored.
        drive(4'b0101, 2'b11, 1'b1);
        expect_at(1, 4'b1000, 4'b0101, "R4 sink opened");
        expect_at(D + 1, 4'b1010, 4'b0101, "R4 source restored");
        idle(D + 3);

        // R3: brake on bridge 1.
        drive(4'b1101, 2'b11, 1'b1);
        expect_at(1, 4'b0010, 4'b0101, "R3 brake source opened");
        expect_at(D + 1, 4'b0010, 4'b1101, "R3 brake both sinks");
        idle(D + 3);

        // R3: permit low during brake has no effect.
        drive(4'b1101, 2'b01, 1'b1);
        expect_at(2, 4'b0010, 4'b1101, "R3 brake ignores permit");
        expect_at(D + 2, 4'b0010, 4'b1101, "R3 brake ignores permit late");
        idle(D + 3);
        drive(4'b1101, 2'b11, 1'b1);
        idle(2);

        // R2: all commands zero.
        drive(4'b0000, 2'b11, 1'b1);
        expect_at(1, 4'b0000, 4'b0000, "R2 all open");
        expect_at(D + 2, 4'b0000, 4'b0000, "R2 stays open");
        idle(D + 3);

        // R7: long idle, forward turns on in one edge.
        drive(4'b0010, 2'b11, 1'b1);
        expect_at(1, 4'b0001, 4'b0010, "R7 on after idle");
        idle(D + 2);

        // R6: brief release then re-request still waits the full gap.
        drive(4'b0000, 2'b11, 1'b1);
        expect_at(1, 4'b0000, 4'b0000, "R6 release");
        expect_at(D, 4'b0000, 4'b0000, "R6 short idle still open");
        expect_at(D + 1, 4'b0001, 4'b0010, "R6 reclose after gap");
        drive(4'b0010, 2'b11, 1'b1);
        idle(D + 3);

        // R8: enable low acts in the same cycle.
        drive(4'b0010, 2'b11, 1'b0);
        expect_at(0, 4'b0000, 4'b0000, "R8 immediate off");
        expect_at(3, 4'b0000, 4'b0000, "R8 held off");
        idle(D + 4);
        drive(4'b0010, 2'b11, 1'b1);
        expect_at(0, 4'b0000, 4'b0000, "R8 state cleared");
        expect_at(1, 4'b0001, 4'b0010, "R8 resume");
        idle(3);

        while (sb.size() != 0) @(posedge clk);
        idle(1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule